// File: doc/BRIEF.md
# Address Translation Cache with Hardware Table Walk

This block turns 32-bit virtual addresses into 30-bit physical addresses for 4 KB pages. It keeps a small fully associative store of recent translations. When the virtual page number of a request matches a stored entry, the block returns the stored physical page number joined to the untouched 12-bit page offset in the same cycle.

When no entry matches, a hardware walker fetches one 32-bit page-table word from memory. The word's address is the page-table base input plus four times the virtual page number. If the word marks the page as present, the walker installs the translation and the held request is looked up again, which now hits. If the page is absent, the block signals a page fault for one cycle and installs nothing.

A requester raises `req_valid` with an address and holds both unchanged until it sees either `rsp_hit` or `rsp_fault`. It then drops the request before the next rising edge. A flush input empties the store in one cycle.

Top module: `addr_xlate_top`

## Requirements
- R1: On a hit, `rsp_paddr[11:0]` equals `req_vaddr[11:0]` and `rsp_paddr[29:12]` equals the physical page number stored for virtual page `req_vaddr[31:12]`.
- R2: A request whose page is stored completes with `rsp_hit` in the cycle it is presented while the walker is idle, with no memory read.
- R3: On a miss the walker raises `mem_rd_valid` with `mem_rd_addr` = `pt_base` + 4 × `req_vaddr[31:12]` (modulo 2^32), and holds both stable until `mem_rd_ready` is high; exactly one read is issued per miss.
- R4: A returned page-table word with bit 31 set installs bits 17..0 as the physical page number, after which the held request is replayed and completes with `rsp_hit`.
- R5: A returned word with bit 31 clear raises `rsp_fault` for exactly one cycle and installs nothing, so a repeated access to that page walks and faults again.
- R6: The store holds 16 entries and no page is ever stored twice. A fill uses the lowest-numbered empty entry if one exists; otherwise it uses a rotating pointer that starts at 0 after reset, advances by one (wrapping) only on such a replacing fill, and is not moved by a flush.
- R7: A one-cycle pulse on `flush` invalidates every entry, so each page accessed afterwards misses once.
- R8: After reset all entries are empty and `rsp_hit`, `rsp_fault` and `mem_rd_valid` are low.
- R9: While a walk is in progress, `rsp_hit` and `rsp_fault` are never both high, and no hit is reported before the walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all stored translations |
| pt_base | input | 32 | Byte address of the page table |
| req_valid | input | 1 | Translation request held until completion |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_hit | output | 1 | Request completed with a translation |
| rsp_fault | output | 1 | Request completed with a page fault |
| rsp_paddr | output | 30 | Physical address, valid with `rsp_hit` |
| mem_rd_valid | output | 1 | Page-table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the page-table word |
| mem_rsp_valid | input | 1 | Read data is returned this cycle |
| mem_rsp_data | input | 32 | Page-table word |

## Verification
A corrupted valid bit or tag shows at the ports in one of two ways: as an unexpected memory read on an access that should hit, or as a missing read on an access that should miss. This shows up on the next access to that page. A wrong victim choice stays hidden until the evicted or the retained page is touched again, so the bench keeps its own model of the 16 entries and the rotating pointer. After each completion it compares how many reads were issued. A wrong stored page number or bad offset handling shows up immediately in `rsp_paddr` on the hit that follows the fill.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W        = 32;
  localparam int PA_W        = 30;
  localparam int OFF_W       = 12;
  localparam int VPN_W       = VA_W - OFF_W;
  localparam int PPN_W       = PA_W - OFF_W;
  localparam int PTE_W       = 32;
  localparam int PTE_PRESENT = 31;

  typedef logic [VPN_W-1:0] vpn_t;
  typedef logic [PPN_W-1:0] ppn_t;
  typedef logic [OFF_W-1:0] off_t;

  typedef enum logic [1:0] {WK_IDLE, WK_REQ, WK_WAIT, WK_FAULT} walk_state_e;

  // byte address of the table word for a page
  function automatic logic [VA_W-1:0] pte_addr(input logic [VA_W-1:0] base, input vpn_t vpn);
    return base + (VA_W'(vpn) << 2);
  endfunction

  function automatic logic pte_present(input logic [PTE_W-1:0] w);
    return w[PTE_PRESENT];
  endfunction

  function automatic ppn_t pte_ppn(input logic [PTE_W-1:0] w);
    return w[PPN_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input ppn_t ppn, input off_t off);
    return {ppn, off};
  endfunction
endpackage

// File: rtl/xlate_tag_array.sv
module xlate_tag_array
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  vpn_t               lk_vpn,
  output logic               lk_hit,
  output ppn_t               lk_ppn,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  vpn_t               fill_vpn,
  input  ppn_t               fill_ppn,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ENTRIES-1:0] valid_q;
  vpn_t               tag_q [ENTRIES];
  ppn_t               ppn_q [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid_q <= '0;
    else if (flush)   valid_q <= '0;
    else if (fill_en) valid_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx] <= fill_vpn;
      ppn_q[fill_idx] <= fill_ppn;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_vpn);
  end

  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) lk_ppn = lk_ppn | ppn_q[i];
  end

  assign lk_hit    = |hit_vec;
  assign valid_vec = valid_q;

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));  // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));  // R7
endmodule

// File: rtl/xlate_victim.sv
module xlate_victim
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_en,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_vec[i] && !any_free) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim_idx = any_free ? free_idx : ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (fill_en && !any_free)
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  AST_PTR_HOLDS_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && any_free) |=> $stable(ptr_q));  // R6
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  vpn_t             start_vpn,
  input  logic [VA_W-1:0]  pt_base,
  output logic             idle,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [VA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             fill_en,
  output vpn_t             fill_vpn,
  output ppn_t             fill_ppn,
  output logic             fault
);
  walk_state_e     state_q, state_d;
  logic [VA_W-1:0] addr_q;
  vpn_t            vpn_q;
  logic            pte_ok;
  logic            unused_pte_bits;

  assign pte_ok          = pte_present(mem_rsp_data);
  assign unused_pte_bits = ^mem_rsp_data[PTE_PRESENT-1:PPN_W];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WK_IDLE:  if (start) state_d = WK_REQ;
      WK_REQ:   if (mem_rd_ready) state_d = WK_WAIT;
      WK_WAIT:  if (mem_rsp_valid) state_d = pte_ok ? WK_IDLE : WK_FAULT;
      WK_FAULT: state_d = WK_IDLE;
      default:  state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      addr_q  <= '0;
      vpn_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == WK_IDLE && start) begin
        addr_q <= pte_addr(pt_base, start_vpn);
        vpn_q  <= start_vpn;
      end
    end
  end

  assign idle         = (state_q == WK_IDLE);
  assign mem_rd_valid = (state_q == WK_REQ);
  assign mem_rd_addr  = addr_q;
  assign fill_en      = (state_q == WK_WAIT) && mem_rsp_valid && pte_ok;
  assign fill_vpn     = vpn_q;
  assign fill_ppn     = pte_ppn(mem_rsp_data);
  assign fault        = (state_q == WK_FAULT);

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));  // R3
  AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);  // R5
  AST_NO_FILL_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> !$past(fill_en));  // R5
endmodule

// File: rtl/addr_xlate_top.sv
module addr_xlate_top
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic [31:0] pt_base,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  output logic        rsp_hit,
  output logic        rsp_fault,
  output logic [29:0] rsp_paddr,
  output logic        mem_rd_valid,
  input  logic        mem_rd_ready,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  vpn_t               req_vpn;
  off_t               req_off;
  logic               lk_hit;
  ppn_t               lk_ppn;
  logic               walk_idle;
  logic               walk_start;
  logic               fill_en;
  vpn_t               fill_vpn;
  ppn_t               fill_ppn;
  logic [IDX_W-1:0]   victim_idx;
  logic [ENTRIES-1:0] valid_vec;

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];
  assign req_off = req_vaddr[OFF_W-1:0];

  xlate_tag_array #(.ENTRIES(ENTRIES)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lk_vpn    (req_vpn),
    .lk_hit    (lk_hit),
    .lk_ppn    (lk_ppn),
    .fill_en   (fill_en),
    .fill_idx  (victim_idx),
    .fill_vpn  (fill_vpn),
    .fill_ppn  (fill_ppn),
    .valid_vec (valid_vec)
  );

  xlate_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (valid_vec),
    .fill_en    (fill_en && !flush),
    .victim_idx (victim_idx)
  );

  assign walk_start = req_valid && walk_idle && !lk_hit;

  xlate_walker u_walker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (walk_start),
    .start_vpn     (req_vpn),
    .pt_base       (pt_base),
    .idle          (walk_idle),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .fill_en       (fill_en),
    .fill_vpn      (fill_vpn),
    .fill_ppn      (fill_ppn),
    .fault         (rsp_fault)
  );

  assign rsp_hit   = req_valid && walk_idle && lk_hit;
  assign rsp_paddr = join_pa(lk_ppn, req_off);

  AST_HIT_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_fault));  // R9
  AST_NO_HIT_WHILE_READING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !rsp_hit);  // R9
  AST_REPLAY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush && req_valid && (req_vpn == fill_vpn)) |=>
      (!req_valid || (req_vpn != $past(fill_vpn)) || rsp_hit));  // R4
endmodule

// File: tb/test_addr_xlate_top.sv
module test_addr_xlate_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_ENT      = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] pt_base = 32'h0004_0000;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        rsp_hit, rsp_fault, mem_rd_valid;
  logic [29:0] rsp_paddr;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_xlate_top i_addr_xlate_top (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
    .req_valid(req_valid), .req_vaddr(req_vaddr),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // ---------------- page table in bench terms ----------------
  function automatic bit pg_present(input logic [19:0] vpn);
    return (vpn % 3) != 0;
  endfunction
  function automatic logic [17:0] pg_frame(input logic [19:0] vpn);
    return 18'((vpn * 7) + 5);
  endfunction
  function automatic logic [31:0] pg_word(input logic [19:0] vpn);
    return {pg_present(vpn), vpn[12:0], pg_frame(vpn)};
  endfunction

  // ---------------- memory responder ----------------
  int          tick = 0;
  bit          pend = 0;
  int          dly = 0;
  logic [31:0] pend_addr = '0;

  always @(posedge clk) begin
    tick <= tick + 1;
    mem_rd_ready <= (tick % 3) != 1;
    mem_rsp_valid <= 1'b0;
    if (mem_rd_valid && mem_rd_ready) begin
      pend <= 1; pend_addr <= mem_rd_addr; dly <= 2;
    end else if (pend) begin
      if (dly == 0) begin
        pend <= 0;
        mem_rsp_valid <= 1'b1;
        mem_rsp_data <= pg_word(20'((pend_addr - pt_base) >> 2));
      end else dly <= dly - 1;
    end
  end

  // ---------------- reference store model ----------------
  bit          m_valid [N_ENT];
  logic [19:0] m_vpn   [N_ENT];
  int          m_ptr = 0;

  function automatic bit m_has(input logic [19:0] vpn);
    for (int i = 0; i < N_ENT; i++) if (m_valid[i] && m_vpn[i] == vpn) return 1;
    return 0;
  endfunction

  function automatic void m_install(input logic [19:0] vpn);
    int slot = -1;
    for (int i = 0; i < N_ENT; i++) if (!m_valid[i] && slot < 0) slot = i;
    if (slot < 0) begin slot = m_ptr; m_ptr = (m_ptr + 1) % N_ENT; end
    m_valid[slot] = 1; m_vpn[slot] = vpn;
  endfunction

  // ---------------- scoreboard ----------------
  typedef struct {
    bit          fault;
    logic [29:0] pa;
    int          walks;
    string       tag;
  } exp_t;
  exp_t        sb_q[$];
  int          walk_cnt = 0;
  logic [31:0] cur_va = '0;

  always @(negedge clk) begin
    if (mem_rd_valid && mem_rd_ready) begin
      walk_cnt++;
      checks++;
      if (mem_rd_addr !== pt_base + {10'd0, cur_va[31:12], 2'b00}) begin
        errors++;
        $display("FAIL R3: table read address actual %h expected %h",
                 mem_rd_addr, pt_base + {10'd0, cur_va[31:12], 2'b00});
      end
    end
    if (req_valid && (rsp_hit || rsp_fault)) begin
      exp_t e;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R9: completion with nothing expected, hit %b fault %b", rsp_hit, rsp_fault);
      end else begin
        e = sb_q.pop_front();
        if (rsp_hit && rsp_fault) begin
          errors++;
          $display("FAIL R9: hit and fault together, actual 11 expected one");
        end else if (rsp_fault != e.fault) begin
          errors++;
          $display("FAIL R5 (%s): fault actual %b expected %b", e.tag, rsp_fault, e.fault);
        end else if (rsp_hit && rsp_paddr !== e.pa) begin
          errors++;
          $display("FAIL R1/R4 (%s): paddr actual %h expected %h", e.tag, rsp_paddr, e.pa);
        end
        checks++;
        if (walk_cnt != e.walks) begin
          errors++;
          $display("FAIL R2/R6 (%s): table reads actual %0d expected %0d", e.tag, walk_cnt, e.walks);
        end
      end
      walk_cnt = 0;
    end
  end

  // ---------------- driver ----------------
  task automatic access(input logic [31:0] va, input string tag);
    exp_t e;
    logic [19:0] vpn = va[31:12];
    e.tag = tag;
    if (m_has(vpn)) begin
      e.fault = 0; e.walks = 0; e.pa = {pg_frame(vpn), va[11:0]};
    end else if (pg_present(vpn)) begin
      e.fault = 0; e.walks = 1; e.pa = {pg_frame(vpn), va[11:0]};
      m_install(vpn);
    end else begin
      e.fault = 1; e.walks = 1; e.pa = '0;
    end
    sb_q.push_back(e);
    @(negedge clk); #1;
    cur_va = va; req_vaddr = va; req_valid = 1'b1;
    forever begin
      @(negedge clk); #1;
      if (rsp_hit || rsp_fault) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); #1;
    flush = 1'b1;
    @(negedge clk); #1;
    flush = 1'b0;
    for (int i = 0; i < N_ENT; i++) m_valid[i] = 0;
  endtask

  function automatic logic [31:0] va_of(input logic [19:0] vpn, input logic [11:0] off);
    return {vpn, off};
  endfunction

  initial begin
    for (int i = 0; i < N_ENT; i++) begin m_valid[i] = 0; m_vpn[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_hit || rsp_fault || mem_rd_valid) begin
      errors++;
      $display("FAIL R8: after reset hit/fault/rd actual %b%b%b expected 000", rsp_hit, rsp_fault, mem_rd_valid);
    end

    access(va_of(20'h00001, 12'hABC), "R8 first miss after reset, R4 fill");
    access(va_of(20'h00001, 12'h123), "R2 hit, R1 offset");
    access(va_of(20'h00003, 12'h010), "R5 absent page faults");
    access(va_of(20'h00003, 12'h010), "R5 fault not installed");
    access(va_of(20'hFFFFE, 12'hFFF), "R1 top page, all-ones offset");
    access(va_of(20'hFFFFE, 12'h000), "R1 zero offset");

    // fill remaining entries, then overflow to force rotation (R6)
    for (int v = 4; v < 40; v++) begin
      if (pg_present(20'(v))) access(va_of(20'(v), 12'(v * 13)), "R6 fill/evict");
    end
    access(va_of(20'h00001, 12'h444), "R6 evicted page walks again");
    access(va_of(20'h00025, 12'h001), "R6 retained page hits");

    pt_base = 32'h0010_0800;
    access(va_of(20'h00200, 12'h0F0), "R3 new table base");
    pt_base = 32'hFFFF_F000;
    access(va_of(20'h00401, 12'h0F1), "R3 base wraps");

    do_flush();
    access(va_of(20'h00200, 12'h0F0), "R7 miss after flush");
    access(va_of(20'h00200, 12'h0F4), "R7 refilled hit");
    access(va_of(20'h00401, 12'h0F1), "R7 second page misses");

    repeat (4) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R9: outstanding expectations actual %0d expected 0", sb_q.size());
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL R9: watchdog expired, actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule